// File: doc/BRIEF.md
# Segmented Physical Address Generator

This block turns a segment:offset pair into a 20-bit physical bus address. It keeps four 16-bit segment bases (code, data, extra, stack) and an instruction pointer. For each memory request it picks a base from the kind of access, unless an override selects another. It then shifts that base left four bits, adds the zero-extended offset, and keeps only the low 20 bits. Port I/O requests bypass the segment completely: the 16-bit port number goes out with the upper four address bits cleared.

The address is available combinationally in the same cycle as the request. It is also captured into an output register when the request is marked valid. The same adder runs permanently on the code base and the instruction pointer to form the fetch address. Right after reset this is the start-up address. A single write port loads the segment bases and the instruction pointer.

Top module: `seg_addr_gen`

## Requirements
- R1: For a memory request the address equals segment base times 16 plus the offset, taken modulo 2^20; the result is 20 bits wide.
- R2: A sum above FFFFFh wraps into low memory; for example base FFFFh with offset FFFFh gives 0FFEFh.
- R3: Without override the access kind selects the base: kind 2'b00 (instruction fetch) uses code, kind 2'b01 (stack) uses stack, kind 2'b10 (data operand) uses data.
- R4: Kind 2'b11 (port I/O) outputs the offset on bits 15:0 and zero on bits 19:16, whatever the segment bases and the override inputs hold.
- R5: Reset sets the code base to F000h, the instruction pointer to FFF0h and the other three bases to 0000h, so the fetch address output reads FFFF0h.
- R6: When the override enable is high on a stack or data request, the override selector picks the base (2'b00 code, 2'b01 data, 2'b10 extra, 2'b11 stack); the override is ignored for instruction fetch and port I/O.
- R7: A write with index 0..3 loads the base with the R6 encoding, and index 4 loads the instruction pointer; indices 5..7 change nothing. The new value is used from the next cycle on.
- R8: On a clock edge with the request valid, the registered address takes the combinational address and the valid output is high for the next cycle; without a valid request the registered address holds and the valid output is low.
- R9: Different segment:offset pairs that name the same location (for example 0042h:004Ch and 0046h:000Ch, both 0046Ch) give the same physical address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_idx | input | 3 | Write target: 0 code, 1 data, 2 extra, 3 stack, 4 instruction pointer |
| wr_data | input | 16 | Write value |
| req_valid | input | 1 | Request strobe that captures the address |
| req_kind | input | 2 | Access kind: fetch, stack, data, port I/O |
| req_ovr_en | input | 1 | Segment override enable |
| req_ovr_sel | input | 2 | Override base selector |
| req_off | input | 16 | Offset, or port number for I/O |
| comb_addr | output | 20 | Combinational physical address |
| phys_addr | output | 20 | Registered physical address |
| phys_vld | output | 1 | Registered address is new this cycle |
| boot_addr | output | 20 | Fetch address formed from code base and instruction pointer |

## Verification
On every cycle the assertions check the fetch sum against the code base, the zero-filled I/O path, the capture and hold of the registered address, and the start-up fetch address at reset release. Override selection, the default base for each access kind, the ignored write indices, wrap-around and the aliasing of pairs that name the same location show only in the bench scenarios. There, a behavioural model tracks every register write and predicts each address.

// File: rtl/seg_addr_pkg.sv
package seg_addr_pkg;

   typedef enum logic [1:0] {
      KIND_FETCH = 2'b00,
      KIND_STACK = 2'b01,
      KIND_DATA  = 2'b10,
      KIND_IO    = 2'b11
   } acc_kind_e;

   typedef enum logic [1:0] {
      SEG_CODE  = 2'b00,
      SEG_DATA  = 2'b01,
      SEG_EXTRA = 2'b10,
      SEG_STACK = 2'b11
   } seg_id_e;

   localparam int unsigned NUM_SEG = 4;
   localparam int unsigned SEL_W   = 2;
   localparam int unsigned IDX_W   = 3;
   localparam logic [IDX_W-1:0] IP_IDX = 3'd4;

endpackage

// File: rtl/seg_regfile.sv
module seg_regfile
   import seg_addr_pkg::*;
#(
   parameter int unsigned SEG_W = 16,
   parameter int unsigned OFF_W = 16,
   parameter logic [SEG_W-1:0] CODE_RST = 16'hF000,
   parameter logic [OFF_W-1:0] IP_RST = 16'hFFF0
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_en,
   input  logic [IDX_W-1:0]         wr_idx,
   input  logic [SEG_W-1:0]         wr_data,
   output logic [NUM_SEG*SEG_W-1:0] seg_flat,
   output logic [OFF_W-1:0]         ip_q
);

   for (genvar i = 0; i < NUM_SEG; i++) begin : g_seg
      localparam logic [SEG_W-1:0] RST_VAL = (i == int'(SEG_CODE)) ? CODE_RST : '0;
      logic [SEG_W-1:0] base_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            base_q <= RST_VAL;
         end else if (wr_en && (wr_idx == IDX_W'(i))) begin
            base_q <= wr_data;
         end
      end

      assign seg_flat[i*SEG_W +: SEG_W] = base_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ip_q <= IP_RST;
      end else if (wr_en && (wr_idx == IP_IDX)) begin
         ip_q <= wr_data[OFF_W-1:0];
      end
   end

endmodule

// File: rtl/seg_select.sv
module seg_select
   import seg_addr_pkg::*;
#(
   parameter int unsigned SEG_W = 16,
   parameter bit ALLOW_OVERRIDE = 1'b1
) (
   input  logic [1:0]               kind,
   input  logic                     ovr_en,
   input  logic [SEL_W-1:0]         ovr_sel,
   input  logic [NUM_SEG*SEG_W-1:0] seg_flat,
   output logic [SEG_W-1:0]         seg_val,
   output logic                     use_seg
);

   logic    ovr_act;
   seg_id_e pick;

   if (ALLOW_OVERRIDE) begin : g_ovr
      assign ovr_act = ovr_en;
   end else begin : g_no_ovr
      logic unused_ovr;
      assign unused_ovr = ovr_en;
      assign ovr_act    = 1'b0;
   end

   always_comb begin
      pick = SEG_DATA;
      unique case (acc_kind_e'(kind))
         KIND_FETCH: pick = SEG_CODE;
         KIND_STACK: pick = ovr_act ? seg_id_e'(ovr_sel) : SEG_STACK;
         KIND_DATA:  pick = ovr_act ? seg_id_e'(ovr_sel) : SEG_DATA;
         KIND_IO:    pick = SEG_DATA;
         default:    pick = SEG_DATA;
      endcase
   end

   assign seg_val = seg_flat[int'(pick)*SEG_W +: SEG_W];
   assign use_seg = (acc_kind_e'(kind) != KIND_IO);

endmodule

// File: rtl/seg_adder.sv
module seg_adder #(
   parameter int unsigned SEG_W = 16,
   parameter int unsigned OFF_W = 16,
   parameter int unsigned SHIFT = 4
) (
   input  logic [SEG_W-1:0]       seg,
   input  logic [OFF_W-1:0]       off,
   input  logic                   bypass,
   output logic [SEG_W+SHIFT-1:0] addr
);

   localparam int unsigned PA_W  = SEG_W + SHIFT;
   localparam int unsigned SUM_W = PA_W + 1;

   logic [SUM_W-1:0] seg_ext;
   logic [SUM_W-1:0] off_ext;
   logic [SUM_W-1:0] sum;
   logic             unused_carry;

   assign seg_ext      = SUM_W'(seg) << SHIFT;
   assign off_ext      = SUM_W'(off);
   assign sum          = seg_ext + off_ext;
   assign unused_carry = sum[SUM_W-1];

   assign addr = bypass ? off_ext[PA_W-1:0] : sum[PA_W-1:0];

endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
   import seg_addr_pkg::*;
#(
   parameter int unsigned SEG_W = 16,
   parameter int unsigned OFF_W = 16,
   parameter int unsigned SHIFT = 4,
   parameter logic [SEG_W-1:0] CODE_RST = 16'hF000,
   parameter logic [OFF_W-1:0] IP_RST = 16'hFFF0,
   parameter bit ALLOW_OVERRIDE = 1'b1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   wr_en,
   input  logic [2:0]             wr_idx,
   input  logic [SEG_W-1:0]       wr_data,
   input  logic                   req_valid,
   input  logic [1:0]             req_kind,
   input  logic                   req_ovr_en,
   input  logic [1:0]             req_ovr_sel,
   input  logic [OFF_W-1:0]       req_off,
   output logic [SEG_W+SHIFT-1:0] comb_addr,
   output logic [SEG_W+SHIFT-1:0] phys_addr,
   output logic                   phys_vld,
   output logic [SEG_W+SHIFT-1:0] boot_addr
);

   localparam int unsigned PA_W = SEG_W + SHIFT;

   if (SEG_W < 1) begin : g_bad_seg
      $error("SEG_W must be at least 1");
   end
   if (SHIFT < 1) begin : g_bad_shift
      $error("SHIFT must be at least 1");
   end
   if (OFF_W > SEG_W) begin : g_bad_off
      $error("OFF_W must not exceed SEG_W");
   end

   logic [NUM_SEG*SEG_W-1:0] seg_flat;
   logic [OFF_W-1:0]         ip_q;
   logic [SEG_W-1:0]         seg_val;
   logic                     use_seg;

   seg_regfile #(
      .SEG_W(SEG_W), .OFF_W(OFF_W), .CODE_RST(CODE_RST), .IP_RST(IP_RST)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
      .wr_data(wr_data), .seg_flat(seg_flat), .ip_q(ip_q)
   );

   seg_select #(
      .SEG_W(SEG_W), .ALLOW_OVERRIDE(ALLOW_OVERRIDE)
   ) u_sel (
      .kind(req_kind), .ovr_en(req_ovr_en), .ovr_sel(req_ovr_sel),
      .seg_flat(seg_flat), .seg_val(seg_val), .use_seg(use_seg)
   );

   seg_adder #(
      .SEG_W(SEG_W), .OFF_W(OFF_W), .SHIFT(SHIFT)
   ) u_req_add (
      .seg(seg_val), .off(req_off), .bypass(!use_seg), .addr(comb_addr)
   );

   seg_adder #(
      .SEG_W(SEG_W), .OFF_W(OFF_W), .SHIFT(SHIFT)
   ) u_boot_add (
      .seg(seg_flat[int'(SEG_CODE)*SEG_W +: SEG_W]), .off(ip_q),
      .bypass(1'b0), .addr(boot_addr)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phys_addr <= '0;
         phys_vld  <= 1'b0;
      end else begin
         phys_vld <= req_valid;
         if (req_valid) begin
            phys_addr <= comb_addr;
         end
      end
   end

   logic [PA_W-1:0] unused_pa;
   assign unused_pa = '0;

endmodule

// File: rtl/seg_addr_chk.sv
module seg_addr_chk #(
   parameter int unsigned SEG_W = 16,
   parameter int unsigned OFF_W = 16,
   parameter int unsigned SHIFT = 4,
   parameter logic [SEG_W-1:0] CODE_RST = 16'hF000,
   parameter logic [OFF_W-1:0] IP_RST = 16'hFFF0
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   req_valid,
   input logic [1:0]             req_kind,
   input logic [OFF_W-1:0]       req_off,
   input logic [SEG_W+SHIFT-1:0] comb_addr,
   input logic [SEG_W+SHIFT-1:0] phys_addr,
   input logic                   phys_vld,
   input logic [SEG_W+SHIFT-1:0] boot_addr,
   input logic [SEG_W-1:0]       code_seg
);

   localparam int unsigned PA_W = SEG_W + SHIFT;

   logic [PA_W:0] fetch_sum;
   logic [PA_W:0] boot_sum;
   assign fetch_sum = ((PA_W+1)'(code_seg) << SHIFT) + (PA_W+1)'(req_off);
   assign boot_sum  = ((PA_W+1)'(CODE_RST) << SHIFT) + (PA_W+1)'(IP_RST);

   // R1, R2: fetch address is code base * 16 + offset, truncated
   a_r1_fetch_sum: assert property (@(posedge clk) disable iff (!rst_n)
      (req_kind == 2'b00) |-> (comb_addr == fetch_sum[PA_W-1:0]));

   // R4: port I/O passes the offset with upper bits zero
   a_r4_io_pass: assert property (@(posedge clk) disable iff (!rst_n)
      (req_kind == 2'b11) |-> (comb_addr == PA_W'(req_off)));

   // R5: fetch address right after reset release
   a_r5_boot: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (boot_addr == boot_sum[PA_W-1:0]));

   // R8: valid request is captured
   a_r8_capture: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> (phys_vld && (phys_addr == $past(comb_addr))));

   // R8: no request, output holds
   a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> (!phys_vld && $stable(phys_addr)));

endmodule

bind seg_addr_gen seg_addr_chk #(
   .SEG_W(SEG_W), .OFF_W(OFF_W), .SHIFT(SHIFT),
   .CODE_RST(CODE_RST), .IP_RST(IP_RST)
) u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
   .req_off(req_off), .comb_addr(comb_addr), .phys_addr(phys_addr),
   .phys_vld(phys_vld), .boot_addr(boot_addr),
   .code_seg(seg_flat[SEG_W-1:0])
);

// File: tb/seg_addr_gen_tb.sv
`timescale 1ns/1ps
module seg_addr_gen_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_idx = '0;
   logic [15:0] wr_data = '0;
   logic        req_valid = 1'b0;
   logic [1:0]  req_kind = '0;
   logic        req_ovr_en = 1'b0;
   logic [1:0]  req_ovr_sel = '0;
   logic [15:0] req_off = '0;
   logic [19:0] comb_addr, phys_addr, boot_addr;
   logic        phys_vld;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   seg_addr_gen dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
      .wr_data(wr_data), .req_valid(req_valid), .req_kind(req_kind),
      .req_ovr_en(req_ovr_en), .req_ovr_sel(req_ovr_sel), .req_off(req_off),
      .comb_addr(comb_addr), .phys_addr(phys_addr), .phys_vld(phys_vld),
      .boot_addr(boot_addr)
   );

   // behavioural reference model
   int m_seg[4];
   int m_ip;
   int exp_phys;
   bit exp_vld;

   function automatic int ref_addr(int kind, bit oe, int os, int off);
      int s;
      if (kind == 3) return off;
      if (kind == 0) s = 0;
      else if (oe) s = os;
      else s = (kind == 1) ? 3 : 1;
      return (m_seg[s] * 16 + off) % 1048576;
   endfunction

   function automatic int ref_boot();
      return (m_seg[0] * 16 + m_ip) % 1048576;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_seg[0] = 'hF000; m_seg[1] = 0; m_seg[2] = 0; m_seg[3] = 0;
         m_ip = 'hFFF0; exp_phys = 0; exp_vld = 1'b0;
      end else begin
         exp_vld = req_valid;
         if (req_valid)
            exp_phys = ref_addr(int'(req_kind), req_ovr_en, int'(req_ovr_sel), int'(req_off));
         if (wr_en) begin
            if (wr_idx < 4) m_seg[wr_idx] = int'(wr_data);
            else if (wr_idx == 4) m_ip = int'(wr_data);
         end
      end
   end

   task automatic check(string tag, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %05h expected %05h", tag, what, act, exp);
      end
   endtask

   // one cycle: check registered outputs, drive, then check combinational ones
   task automatic step(string tag, bit we, int wi, int wd, bit rv, int k,
                       bit oe, int os, int off);
      @(negedge clk);
      check("R8", "phys_vld", int'(phys_vld), int'(exp_vld));
      check("R8", "phys_addr", int'(phys_addr), exp_phys);
      wr_en = we; wr_idx = 3'(wi); wr_data = 16'(wd);
      req_valid = rv; req_kind = 2'(k); req_ovr_en = oe;
      req_ovr_sel = 2'(os); req_off = 16'(off);
      #1;
      check(tag, "comb_addr", int'(comb_addr),
            ref_addr(k, oe, os, off));
      check("R5", "boot_addr", int'(boot_addr), ref_boot());
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R5: reset state
      check("R5", "boot_addr reset", int'(boot_addr), 'hFFFF0);
      check("R8", "phys_vld reset", int'(phys_vld), 0);
      check("R8", "phys_addr reset", int'(phys_addr), 0);
      // R3 at reset: fetch uses code base F000h
      check("R3", "fetch at reset", int'(comb_addr), 'hF0000);
      rst_n = 1'b1;
      @(posedge clk);
      m_seg[0] = 'hF000; m_seg[1] = 0; m_seg[2] = 0; m_seg[3] = 0;
      m_ip = 'hFFF0; exp_phys = 0; exp_vld = 1'b0;

      // R5: data base still zero after reset
      step("R5", 0, 0, 0, 1, 2, 0, 0, 'h1234);
      // R7: load data, extra, stack bases
      step("R7", 1, 1, 'h1234, 0, 2, 0, 0, 'h5678);
      step("R7", 1, 2, 'h2000, 0, 2, 0, 0, 'h5678);
      step("R7", 1, 3, 'h3000, 1, 2, 0, 0, 'h5678);
      // R1: data sum 12340h + 5678h
      step("R1", 0, 0, 0, 1, 2, 0, 0, 'h5678);
      // R3: stack and fetch defaults
      step("R3", 0, 0, 0, 1, 1, 0, 0, 'h0010);
      step("R3", 0, 0, 0, 1, 0, 0, 0, 'h0123);
      // R6: overrides on data and stack, ignored on fetch
      step("R6", 0, 0, 0, 1, 2, 1, 2, 'h0004);
      step("R6", 0, 0, 0, 1, 1, 1, 0, 'h0008);
      step("R6", 0, 0, 0, 1, 0, 1, 3, 'h0100);
      // R4: port I/O, override ignored
      step("R4", 0, 0, 0, 1, 3, 0, 0, 'hABCD);
      step("R4", 0, 0, 0, 1, 3, 1, 2, 'hFFFF);
      // R2: wrap past FFFFFh
      step("R7", 1, 1, 'hFFFF, 0, 2, 0, 0, 0);
      step("R2", 0, 0, 0, 1, 2, 0, 0, 'hFFFF);
      step("R2", 0, 0, 0, 1, 2, 0, 0, 'h0011);
      // R7: indices 5..7 ignored, IP write changes fetch address
      step("R7", 1, 5, 'h0000, 0, 2, 0, 0, 'h0001);
      step("R7", 1, 7, 'h0000, 1, 2, 0, 0, 'h0001);
      step("R7", 1, 4, 'h0000, 1, 1, 0, 0, 'h0002);
      step("R7", 1, 0, 'h0100, 1, 0, 0, 0, 'h0003);
      // R9: aliasing pairs
      step("R7", 1, 1, 'h0042, 0, 2, 0, 0, 0);
      step("R9", 1, 2, 'h0046, 1, 2, 0, 0, 'h004C);
      step("R9", 0, 0, 0, 1, 2, 1, 2, 'h000C);
      // R8: hold with no request
      step("R8", 0, 0, 0, 0, 2, 0, 0, 'h7777);
      step("R8", 0, 0, 0, 0, 1, 0, 0, 'h8888);
      // R1: mixed patterns
      for (int i = 0; i < 40; i++) begin
         step("R1", (i % 3) == 0, i % 5, (i * 'h3C5B) & 'hFFFF, (i % 4) != 1,
              i % 4, (i % 2) == 1, (i / 2) % 4, (i * 'h9E37) & 'hFFFF);
      end
      step("R8", 0, 0, 0, 0, 0, 0, 0, 0);
      step("R8", 0, 0, 0, 0, 0, 0, 0, 0);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule